// File: doc/BRIEF.md
# Windowed watchdog timer

The block is a supervision timer with a 7-bit down counter that software has to reload inside a permitted time window. The counter steps down once per prescaled tick. The tick period is a power of two set by a base exponent parameter plus a 2-bit timebase field. After software arms the block, it emits a one-cycle system reset request in three cases:

- the counter steps from 0x40 to 0x3F;
- software reloads the counter while the counter is still above the programmed window value;
- software writes a counter value whose bit 6 is clear.

When the counter reaches 0x40 it sets a warning flag. An interrupt line carries that flag when the warning interrupt is enabled.

Software reaches the block through a plain synchronous register port. Writes take effect on the clock edge. Read data is a combinational function of the address. The control register sits at offset 0x0, the configuration register at 0x4 and the status register at 0x8. Any other offset reads as zero. The clock edge that raises a reset request also returns every register to its default value.

Top module: `winwd`

## Requirements
- R1: After reset the registers read as follows: control 0x0000007F (counter 0x7F in bits 6:0, arm bit 7 clear), configuration 0x0000007F (window in bits 6:0, timebase in bits 8:7, warning interrupt enable in bit 9), status 0x00000000 (warning flag in bit 0). An unmapped offset reads 0. The reset request and the interrupt are low.
- R2: The counter decrements once every 2^(PRESC_LOG2 + timebase) clock cycles, wrapping from 0x00 to 0x7F. Any write to the control register reloads the counter from data bits 6:0 and restarts the prescaler from zero, so the first decrement comes one full period after the write edge.
- R3: Writing 1 to control bit 7 arms the block. Writing 0 there leaves it armed. Only a reset disarms it.
- R4: While armed, the tick that moves the counter from 0x40 to 0x3F raises the reset request for exactly one cycle. With the counter reloaded to 0x7F this happens 64 periods after the reload edge.
- R5: While not armed, the counter keeps running through 0x3F and wraps, and no reset request is produced.
- R6: The warning flag (status bit 0) is set on the tick where the counter becomes 0x40, whether or not the interrupt is enabled. Writing 0 to status bit 0 clears the flag. Writing 1 there has no effect.
- R7: Configuration bit 9 can be set by software but cleared only by a reset. The interrupt output is high exactly when the flag and this enable are both set.
- R8: A control write while armed, when the current counter is greater than the window value, raises the reset request on that write edge and does not reload the counter.
- R9: A control write while armed, when the counter is less than or equal to the window value, reloads the counter with no reset request. A window of 0x7F therefore never penalises a reload.
- R10: A control write whose counter field has bit 6 clear raises the reset request on that write edge if the block is armed or the same write arms it. If the block is not armed, the value is simply loaded.
- R11: On the edge that raises the reset request, counter, window, timebase, warning interrupt enable, warning flag and arm bit all return to their R1 defaults, and the prescaler restarts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| rst_req | output | 1 | One-cycle system reset request |
| irq | output | 1 | Early-warning interrupt |

## Verification
The reload check is driven with counter values on each side of a 0x50 window: a reload when the counter is 0x51 must reset, and a reload when it is 0x50 must not. A reload straight after arming, with the counter still at 0x7F, must also reset. Timeout is measured as the cycle count from the arming write to the reset pulse under two timebase codes, and the decrement period is measured under all four codes. Together these separate a wrong prescaler width from a wrong terminal value. Counter values with bit 6 clear are written in three states: unarmed, being armed by the same write, and already armed. These cases isolate the immediate-reset rule from the plain load. Sticky and write-zero-to-clear fields are read back after writing both polarities.

// File: rtl/winwd_pkg.sv
`timescale 1ns/1ps
package winwd_pkg;
  localparam int CNT_W = 7;
  localparam int TB_W  = 2;
  localparam int REG_W = 32;

  typedef logic [CNT_W-1:0] cnt_t;

  localparam cnt_t CNT_DEF  = 7'h7F;
  localparam cnt_t WIN_DEF  = 7'h7F;
  localparam cnt_t CNT_WARN = 7'h40;

  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_CFG  = 8'h04;
  localparam logic [7:0] OFS_STAT = 8'h08;

  typedef enum logic [1:0] {SEL_CTRL, SEL_CFG, SEL_STAT, SEL_NONE} sel_e;

  typedef struct packed {
    logic            warn_en;
    logic [TB_W-1:0] tbase;
    cnt_t            win;
  } cfg_t;

  localparam cfg_t CFG_DEF = '{warn_en: 1'b0, tbase: '0, win: WIN_DEF};

  function automatic sel_e f_decode(input logic [7:0] a);
    case (a)
      OFS_CTRL: return SEL_CTRL;
      OFS_CFG:  return SEL_CFG;
      OFS_STAT: return SEL_STAT;
      default:  return SEL_NONE;
    endcase
  endfunction

  // Exponent of the decrement period in clock cycles
  function automatic int f_period_log2(input int base, input logic [TB_W-1:0] tb);
    return base + int'(tb);
  endfunction

  // Counter value is inside the valid range while its top bit is set
  function automatic logic f_in_range(input cnt_t v);
    return v[CNT_W-1];
  endfunction

  function automatic cnt_t f_dec(input cnt_t v);
    return v - cnt_t'(1);
  endfunction

  // A reload is early while the counter still sits above the window
  function automatic logic f_too_early(input cnt_t cnt, input cnt_t win);
    return cnt > win;
  endfunction

  function automatic logic [REG_W-1:0] f_pack_ctrl(input logic armed, input cnt_t cnt);
    return {{(REG_W-CNT_W-1){1'b0}}, armed, cnt};
  endfunction

  function automatic logic [REG_W-1:0] f_pack_cfg(input cfg_t c);
    return {{(REG_W-CNT_W-TB_W-1){1'b0}}, c.warn_en, c.tbase, c.win};
  endfunction

  function automatic logic [REG_W-1:0] f_pack_stat(input logic flag);
    return {{(REG_W-1){1'b0}}, flag};
  endfunction
endpackage

// File: rtl/winwd_prescaler.sv
`timescale 1ns/1ps
module winwd_prescaler
  import winwd_pkg::*;
#(
  parameter int BASE_LOG2 = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic [TB_W-1:0] tbase,
  output logic            tick
);
  localparam int PW = BASE_LOG2 + (1 << TB_W);

  logic [PW-1:0] div_q;
  logic [PW-1:0] lim_m1;

  always_comb begin
    lim_m1 = (PW'(1) << f_period_log2(BASE_LOG2, tbase)) - PW'(1);
    // >= covers a timebase lowered in the middle of a period
    tick   = (div_q >= lim_m1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               div_q <= '0;
    else if (restart || tick) div_q <= '0;
    else                      div_q <= div_q + PW'(1);
  end
endmodule

// File: rtl/winwd_counter.sv
`timescale 1ns/1ps
module winwd_counter
  import winwd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic load,
  input  cnt_t load_val,
  input  logic tick,
  output cnt_t cnt_q,
  output logic reach_warn,
  output logic fall_out
);
  logic step;
  cnt_t dec_val;

  always_comb begin
    step       = tick && !load;
    dec_val    = f_dec(cnt_q);
    reach_warn = step && (dec_val == CNT_WARN);
    fall_out   = step && f_in_range(cnt_q) && !f_in_range(dec_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= CNT_DEF;
    else if (soft_rst) cnt_q <= CNT_DEF;
    else if (load)     cnt_q <= load_val;
    else if (tick)     cnt_q <= dec_val;
  end

  AST_TICK_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && !soft_rst) |=> (cnt_q == cnt_t'($past(cnt_q) - 7'd1))); // R2

  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load && !soft_rst) |=> $stable(cnt_q)); // R2
endmodule

// File: rtl/winwd_regs.sv
`timescale 1ns/1ps
module winwd_regs
  import winwd_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [REG_W-1:0]  wdata,
  input  cnt_t              cnt_q,
  input  logic              reach_warn,
  output logic              ctrl_wr,
  output logic              armed_q,
  output cfg_t              cfg_q,
  output logic              flag_q,
  output logic [REG_W-1:0]  rdata
);
  localparam int ARM_BIT  = CNT_W;
  localparam int TB_LO    = CNT_W;
  localparam int WEN_BIT  = CNT_W + TB_W;

  sel_e sel;
  logic cfg_wr;
  logic stat_wr;
  logic unused_wdata;

  assign unused_wdata = ^wdata[REG_W-1:WEN_BIT+1];

  always_comb begin
    sel     = f_decode(8'(addr));
    ctrl_wr = wr && (sel == SEL_CTRL);
    cfg_wr  = wr && (sel == SEL_CFG);
    stat_wr = wr && (sel == SEL_STAT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cfg_q   <= CFG_DEF;
      flag_q  <= 1'b0;
    end else if (soft_rst) begin
      armed_q <= 1'b0;
      cfg_q   <= CFG_DEF;
      flag_q  <= 1'b0;
    end else begin
      if (ctrl_wr && wdata[ARM_BIT]) armed_q <= 1'b1;
      if (cfg_wr) begin
        cfg_q.win     <= wdata[CNT_W-1:0];
        cfg_q.tbase   <= wdata[TB_LO +: TB_W];
        cfg_q.warn_en <= cfg_q.warn_en | wdata[WEN_BIT];
      end
      if (reach_warn)                flag_q <= 1'b1;
      else if (stat_wr && !wdata[0]) flag_q <= 1'b0;
    end
  end

  always_comb begin
    case (sel)
      SEL_CTRL: rdata = f_pack_ctrl(armed_q, cnt_q);
      SEL_CFG:  rdata = f_pack_cfg(cfg_q);
      SEL_STAT: rdata = f_pack_stat(flag_q);
      default:  rdata = '0;
    endcase
  end

  AST_ARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !soft_rst) |=> armed_q); // R3

  AST_WARN_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.warn_en && !soft_rst) |=> cfg_q.warn_en); // R7

  AST_FLAG_ON_WARN: assert property (@(posedge clk) disable iff (!rst_n)
    (reach_warn && !soft_rst) |=> flag_q); // R6

  AST_FLAG_NO_SET_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !reach_warn) |=> !flag_q); // R6
endmodule

// File: rtl/winwd.sv
`timescale 1ns/1ps
module winwd
  import winwd_pkg::*;
#(
  parameter int PRESC_LOG2 = 12,
  parameter int ADDR_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              rst_req,
  output logic              irq
);
  logic ctrl_wr;
  logic armed_q;
  cfg_t cfg_q;
  logic flag_q;
  cnt_t cnt_q;
  logic reach_warn;
  logic fall_out;
  logic tick;
  logic ev_early;
  logic ev_badval;
  logic ev_timeout;
  logic ev_any;
  logic rst_req_q;
  cnt_t wr_cnt;

  assign wr_cnt = bus_wdata[CNT_W-1:0];

  // Reset causes, named separately for the assertions
  always_comb begin
    ev_early   = ctrl_wr && armed_q && f_too_early(cnt_q, cfg_q.win);
    ev_badval  = ctrl_wr && (armed_q || bus_wdata[CNT_W]) && !f_in_range(wr_cnt);
    ev_timeout = armed_q && fall_out;
    ev_any     = ev_early || ev_badval || ev_timeout;
  end

  winwd_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (ev_any),
    .addr       (bus_addr),
    .wr         (bus_wr),
    .wdata      (bus_wdata),
    .cnt_q      (cnt_q),
    .reach_warn (reach_warn),
    .ctrl_wr    (ctrl_wr),
    .armed_q    (armed_q),
    .cfg_q      (cfg_q),
    .flag_q     (flag_q),
    .rdata      (bus_rdata)
  );

  winwd_prescaler #(.BASE_LOG2(PRESC_LOG2)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (ctrl_wr || ev_any),
    .tbase   (cfg_q.tbase),
    .tick    (tick)
  );

  winwd_counter u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (ev_any),
    .load       (ctrl_wr),
    .load_val   (wr_cnt),
    .tick       (tick),
    .cnt_q      (cnt_q),
    .reach_warn (reach_warn),
    .fall_out   (fall_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req_q <= 1'b0;
    else        rst_req_q <= ev_any;
  end

  assign rst_req = rst_req_q;
  assign irq     = flag_q && cfg_q.warn_en;

  AST_REQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R4

  AST_DEFAULTS_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (cnt_q == CNT_DEF && !armed_q && cfg_q == CFG_DEF && !flag_q)); // R11

  AST_QUIET_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !bus_wr) |=> !rst_req); // R5

  AST_EARLY_RELOAD_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFS_CTRL) && armed_q && cnt_q > cfg_q.win) |=> rst_req); // R8

  AST_TIMEOUT_AT_40: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && tick && !bus_wr && cnt_q == CNT_WARN) |=> rst_req); // R4
endmodule

// File: tb/winwd_bench.sv
`timescale 1ns/1ps
module winwd_bench;
  localparam int PL = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rst_req;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  winwd #(.PRESC_LOG2(PL), .ADDR_W(4)) u_winwd (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req), .irq(irq)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic t_defaults();
    logic [31:0] v;
    do_reset();
    rd(4'h0, v); chk("R1", "control default", v, 32'h7F);
    rd(4'h4, v); chk("R1", "config default", v, 32'h7F);
    rd(4'h8, v); chk("R1", "status default", v, 32'h0);
    rd(4'hC, v); chk("R1", "unmapped read", v, 32'h0);
    chk("R1", "rst_req low", 32'(rst_req), 0);
    chk("R1", "irq low", 32'(irq), 0);
  endtask

  task automatic t_period();
    logic [31:0] v;
    do_reset();
    for (int tb = 0; tb < 4; tb++) begin
      int per;
      per = (1 << (PL + tb));
      wr(4'h4, 32'h7F | (32'(tb) << 7));
      wr(4'h0, 32'h7F);
      for (int i = 1; i <= per; i++) begin
        @(negedge clk);
        if (i == per - 1) begin rd(4'h0, v); chk("R2", "before first step", v, 32'h7F); end
        if (i == per)     begin rd(4'h0, v); chk("R2", "at first step", v, 32'h7E); end
      end
    end
    // reload half way restarts the prescaler (period 4 with timebase 0)
    wr(4'h4, 32'h7F);
    wr(4'h0, 32'h7F);
    @(negedge clk);
    wr(4'h0, 32'h7F);
    repeat (3) @(negedge clk);
    rd(4'h0, v); chk("R2", "prescaler restart on reload", v, 32'h7F);
    @(negedge clk);
    rd(4'h0, v); chk("R2", "step after restart", v, 32'h7E);
  endtask

  task automatic t_unarmed_run();
    logic [31:0] v;
    int seen;
    seen = 0;
    do_reset();
    wr(4'h0, 32'h7F);
    for (int i = 1; i <= 300; i++) begin
      @(negedge clk);
      if (rst_req) seen++;
      if (irq) seen++;
      if (i == 251) begin rd(4'h8, v); chk("R6", "flag before 0x40", v, 0); end
      if (i == 252) begin rd(4'h8, v); chk("R6", "flag at 0x40 without enable", v, 1); end
      if (i == 256) begin rd(4'h0, v); chk("R5", "counter passes 0x3F unarmed", v, 32'h3F); end
    end
    chk("R5", "no request or irq while unarmed", 32'(seen), 0);
    wr(4'h8, 32'h1); rd(4'h8, v); chk("R6", "writing 1 keeps flag", v, 1);
    wr(4'h8, 32'h0); rd(4'h8, v); chk("R6", "writing 0 clears flag", v, 0);
    wr(4'h4, 32'h27F); chk("R7", "irq off with flag clear", 32'(irq), 0);
    wr(4'h4, 32'h07F); rd(4'h4, v); chk("R7", "enable cannot be cleared", v, 32'h27F);
    wr(4'h0, 32'h7F);
    repeat (252) @(negedge clk);
    chk("R7", "irq with flag and enable", 32'(irq), 1);
  endtask

  task automatic timeout_run(input int tb, input int exp_at);
    logic [31:0] v;
    int first;
    first = -1;
    do_reset();
    wr(4'h4, 32'h27F | (32'(tb) << 7));
    wr(4'h0, 32'hFF);
    for (int i = 1; i <= exp_at + 4; i++) begin
      @(negedge clk);
      if (rst_req && first < 0) begin
        first = i;
        rd(4'h0, v); chk("R11", "control cleared with request", v, 32'h7F);
        rd(4'h4, v); chk("R11", "config cleared with request", v, 32'h7F);
        rd(4'h8, v); chk("R11", "status cleared with request", v, 0);
      end
      if (first > 0 && i == first + 1) chk("R4", "request lasts one cycle", 32'(rst_req), 0);
      if (i == exp_at - (exp_at / 64)) chk("R7", "irq at warning", 32'(irq), 1);
    end
    chk("R4", "timeout cycle", 32'(first), 32'(exp_at));
  endtask

  task automatic t_timeout();
    timeout_run(0, 64 * (1 << PL));
    timeout_run(1, 64 * (1 << (PL + 1)));
  endtask

  task automatic t_arm_sticky();
    logic [31:0] v;
    do_reset();
    wr(4'h0, 32'hFF);
    wr(4'h0, 32'h7F);
    chk("R9", "reload with open window", 32'(rst_req), 0);
    rd(4'h0, v); chk("R3", "arm survives write of 0", v, 32'hFF);
  endtask

  task automatic t_window();
    logic [31:0] v;
    do_reset();
    wr(4'h4, 32'h50);
    wr(4'h0, 32'hFF);
    wr(4'h0, 32'hFF);
    chk("R8", "reload at 0x7F above window 0x50", 32'(rst_req), 1);
    rd(4'h0, v); chk("R8", "no reload, registers cleared", v, 32'h7F);

    do_reset();
    wr(4'h4, 32'h50);
    wr(4'h0, 32'hFF);
    repeat (186) @(negedge clk);
    wr(4'h0, 32'hFF);
    chk("R8", "reload at 0x51 with window 0x50", 32'(rst_req), 1);

    do_reset();
    wr(4'h4, 32'h50);
    wr(4'h0, 32'hFF);
    repeat (190) @(negedge clk);
    wr(4'h0, 32'hFF);
    chk("R9", "reload at 0x50 with window 0x50", 32'(rst_req), 0);
    rd(4'h0, v); chk("R9", "counter reloaded", v, 32'hFF);
  endtask

  task automatic t_bad_value();
    logic [31:0] v;
    do_reset();
    wr(4'h0, 32'h3F);
    chk("R10", "unarmed low value no request", 32'(rst_req), 0);
    rd(4'h0, v); chk("R10", "unarmed low value loaded", v, 32'h3F);
    do_reset();
    wr(4'h0, 32'hBF);
    chk("R10", "arming write with bit6 clear", 32'(rst_req), 1);
    do_reset();
    wr(4'h0, 32'hFF);
    wr(4'h0, 32'h3F);
    chk("R10", "armed write with bit6 clear", 32'(rst_req), 1);
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_defaults();
    t_period();
    t_unarmed_run();
    t_timeout();
    t_arm_sticky();
    t_window();
    t_bad_value();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule